// File: doc/BRIEF.md
# Receive Packet FIFO with Admission Filters

This block is the byte buffer between a radio packet engine and the host-side reader. The engine pushes each received packet as a byte stream. The first byte carries the payload length, the second byte carries the destination address, and markers flag the first and final bytes of the packet. A CRC verdict arrives together with the final byte. The block stores the bytes in a circular buffer of `DEPTH` entries (128 by default; it must be a power of two). A packet stays invisible to the reader until it has passed every filter. At that point the block appends a status byte and moves the visible end pointer past the whole packet in a single step.

Bytes of a packet that is still arriving are held in the region beyond the visible end pointer. If the packet is rejected, the write position simply snaps back to the visible end pointer. A packet is rejected when its length byte is over the programmed limit, when its address byte differs from the node address while address checking is enabled, or when its CRC fails while automatic CRC discard is armed. The reason for the most recent outcome is reported as a two-bit code. Two conditions put the block into a sticky error state: a write with no room left, and a read from an empty buffer. Only a flush leaves that state.

Top module: `rx_pkt_fifo`

## Requirements
- R1: After reset or a flush, `fill_count` is 0, `first_ptr` and `last_ptr` are 0, both error flags are 0 and `discard_code` is 0. The flush takes effect at the clock edge where it is sampled.
- R2: An accepted packet becomes readable only at the edge that samples its final byte. At that edge `fill_count` and `last_ptr` advance by the packet length plus one. The reader then sees the packet bytes in arrival order followed by one status byte, whose bit 7 equals `wr_crc_ok` and whose bits 6:0 are 0. `discard_code` becomes 0 (accepted).
- R3: A first byte (the length byte) greater than `cfg_max_len` discards the packet. `discard_code` becomes 2 and no byte of that packet becomes readable.
- R4: When `cfg_addr_chk` is 1, a second packet byte different from `cfg_dev_addr` discards the packet and `discard_code` becomes 1. The comparison uses the byte exactly as it arrives. When `cfg_addr_chk` is 0, any address is accepted.
- R5: When automatic CRC discard is armed, a packet whose final byte arrives with `wr_crc_ok` = 0 is rolled back, `discard_code` becomes 3, and `last_ptr` and `fill_count` do not move. When it is not armed, the packet is kept with status bit 7 = 0.
- R6: Automatic CRC discard is armed out of reset. It disarms whenever `cfg_crc_flush_en` is 0. Setting `cfg_crc_flush_en` to 1 again re-arms it only at the next flush.
- R7: A byte is written only if it fits. The byte needs one free entry, or two when it is the final byte because the status byte follows it. Room is counted against the readable bytes plus the pending bytes of the current packet, using the count from before the edge. A byte that does not fit sets `ovf_flag` and abandons the packet.
- R8: A read request while `fill_count` is 0 sets `udf_flag`.
- R9: While either error flag is set, reads and writes have no effect and the flags stay set. Only `flush` clears them.
- R10: `thr_hit` is 1 exactly when `fill_count` is greater than or equal to `cfg_thr`.
- R11: `rd_en` with `fill_count` > 0 removes the byte shown on `rd_data` (the byte at `first_ptr`). The pointers wrap modulo `DEPTH`.
- R12: Bytes that arrive outside a packet (no start marker since the last final byte or flush) are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Incoming byte valid |
| wr_data | input | 8 | Incoming byte |
| wr_sop | input | 1 | Byte is the first (length) byte of a packet |
| wr_eop | input | 1 | Byte is the final byte of a packet |
| wr_crc_ok | input | 1 | CRC verdict, sampled with the final byte |
| rd_en | input | 1 | Remove the byte on rd_data |
| flush | input | 1 | Empty the buffer and leave the error state |
| cfg_addr_chk | input | 1 | Enable address filtering |
| cfg_dev_addr | input | 8 | Node address |
| cfg_max_len | input | 8 | Largest accepted length byte |
| cfg_crc_flush_en | input | 1 | Enable automatic CRC discard |
| cfg_thr | input | 8 | Fill threshold |
| rd_data | output | 8 | Byte at the read position |
| fill_count | output | 8 | Readable bytes |
| first_ptr | output | 7 | Read position |
| last_ptr | output | 7 | End of readable data |
| thr_hit | output | 1 | Fill count at or above threshold |
| ovf_flag | output | 1 | Overflow occurred (sticky) |
| udf_flag | output | 1 | Underflow occurred (sticky) |
| discard_code | output | 2 | Last outcome: 0 accepted, 1 address, 2 length, 3 CRC |

## Verification
The in-line assertions check several properties on every cycle. The visible end pointer only moves on a final byte or a flush. The fill count stays within the buffer and always equals the distance between the two pointers. The error flags are sticky, and the error state freezes the pointers. A flush empties the buffer, and CRC discard cannot re-arm without a flush. Other behaviour only shows up in the bench's scenarios, because it depends on data and packet structure. That includes the filter verdicts, the byte order and status byte seen by the reader, the exact overflow boundary at the full buffer, pointer wrap-around, and the re-arm sequence. The bench runs these scenarios against a queue-based model that is compared with the outputs on every clock.

// File: rtl/rxpf_pkg.sv
package rxpf_pkg;
  typedef enum logic [1:0] {
    DISC_NONE = 2'd0,
    DISC_ADDR = 2'd1,
    DISC_LEN  = 2'd2,
    DISC_CRC  = 2'd3
  } disc_e;
endpackage

// File: rtl/rxpf_mem.sv
module rxpf_mem #(
  parameter int DEPTH = 128,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we_a,
  input  logic [AW-1:0] wa_a,
  input  logic [DW-1:0] wd_a,
  input  logic          we_b,
  input  logic [AW-1:0] wa_b,
  input  logic [DW-1:0] wd_b,
  input  logic [AW-1:0] ra,
  output logic [DW-1:0] rd
);
  logic [DW-1:0] mem [DEPTH];

  // Port b carries the status byte and always targets wa_a + 1.
  always_ff @(posedge clk) begin
    if (we_a) mem[wa_a] <= wd_a;
    if (we_b) mem[wa_b] <= wd_b;
  end

  assign rd = mem[ra];
endmodule

// File: rtl/rxpf_admit.sv
module rxpf_admit
  import rxpf_pkg::*;
#(
  parameter int DEPTH = 128,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_valid,
  input  logic [DW-1:0] wr_data,
  input  logic          wr_sop,
  input  logic          wr_eop,
  input  logic          wr_crc_ok,
  input  logic          flush,
  input  logic          err,
  input  logic [CW-1:0] count,
  input  logic [AW-1:0] last,
  input  logic          cfg_addr_chk,
  input  logic [DW-1:0] cfg_dev_addr,
  input  logic [DW-1:0] cfg_max_len,
  input  logic          cfg_crc_flush_en,
  output logic          we_a,
  output logic [AW-1:0] wa_a,
  output logic [DW-1:0] wd_a,
  output logic          we_b,
  output logic [AW-1:0] wa_b,
  output logic [DW-1:0] wd_b,
  output logic          commit,
  output logic [CW-1:0] commit_len,
  output logic          ovf_evt,
  output disc_e         code
);
  logic          in_pkt_q, in_pkt_d, drop_q, drop_d, arm_q, arm_d;
  logic [1:0]    idx_q, idx_d;
  logic [CW-1:0] pend_q, pend_d, ofs, need;
  disc_e         code_q, code_d;
  logic          active, rej_len, rej_addr, kept, room_ok, wr_go, crc_drop;
  logic [CW:0]   sum;

  always_comb begin
    active   = wr_valid && !err && !flush;
    ofs      = wr_sop ? '0 : pend_q;
    need     = wr_eop ? CW'(2) : CW'(1);
    rej_len  = wr_sop && (wr_data > cfg_max_len);
    rej_addr = !wr_sop && in_pkt_q && !drop_q && (idx_q == 2'd1) &&
               cfg_addr_chk && (wr_data != cfg_dev_addr);
    kept     = wr_sop ? !rej_len : (in_pkt_q && !drop_q && !rej_addr);
    sum      = (CW+1)'(count) + (CW+1)'(ofs) + (CW+1)'(need);
    room_ok  = sum <= (CW+1)'(DEPTH);
    ovf_evt  = active && kept && !room_ok;
    wr_go    = active && kept && room_ok;
    crc_drop = !wr_crc_ok && arm_q;
    commit     = wr_go && wr_eop && !crc_drop;
    commit_len = ofs + CW'(2);
    we_a = wr_go;
    wa_a = last + AW'(ofs);
    wd_a = wr_data;
    we_b = wr_go && wr_eop;
    wa_b = wa_a + AW'(1);
    wd_b = {wr_crc_ok, {(DW-1){1'b0}}};
  end

  always_comb begin
    in_pkt_d = in_pkt_q;
    drop_d   = drop_q;
    idx_d    = idx_q;
    pend_d   = pend_q;
    code_d   = code_q;
    arm_d    = cfg_crc_flush_en && (flush || arm_q);
    if (flush) begin
      in_pkt_d = 1'b0;
      drop_d   = 1'b0;
      idx_d    = '0;
      pend_d   = '0;
      code_d   = DISC_NONE;
    end else if (active) begin
      if (ovf_evt) begin
        in_pkt_d = 1'b0;
        drop_d   = 1'b0;
        pend_d   = '0;
      end else if (wr_sop || in_pkt_q) begin
        if (rej_len)       code_d = DISC_LEN;
        else if (rej_addr) code_d = DISC_ADDR;
        if (wr_eop) begin
          in_pkt_d = 1'b0;
          drop_d   = 1'b0;
          pend_d   = '0;
          if (wr_go) code_d = crc_drop ? DISC_CRC : DISC_NONE;
        end else begin
          in_pkt_d = 1'b1;
          if (kept) begin
            drop_d = 1'b0;
            pend_d = ofs + CW'(1);
            idx_d  = wr_sop ? 2'd1 : ((idx_q == 2'd2) ? 2'd2 : idx_q + 2'd1);
          end else begin
            drop_d = 1'b1;
            pend_d = '0;
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_pkt_q <= 1'b0;
      drop_q   <= 1'b0;
      idx_q    <= '0;
      pend_q   <= '0;
      code_q   <= DISC_NONE;
      arm_q    <= 1'b1;
    end else begin
      in_pkt_q <= in_pkt_d;
      drop_q   <= drop_d;
      idx_q    <= idx_d;
      pend_q   <= pend_d;
      code_q   <= code_d;
      arm_q    <= arm_d;
    end
  end

  assign code = code_q;

  // R6: once disarmed, only a flush may re-arm CRC discard
  a_r6_rearm_needs_flush: assert property (@(posedge clk) disable iff (!rst_n)
    (!arm_q && !flush) |=> !arm_q);
  // R3: a rejected packet writes nothing until a new start marker
  a_r3_no_write_when_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (drop_q && !wr_sop) |-> !we_a);
  // R7: pending bytes never exceed the free space
  a_r7_pending_fits: assert property (@(posedge clk) disable iff (!rst_n)
    ((CW+1)'(pend_q) + (CW+1)'(count)) <= (CW+1)'(DEPTH));
endmodule

// File: rtl/rxpf_ptrs.sv
module rxpf_ptrs #(
  parameter int DEPTH = 128,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_en,
  input  logic          flush,
  input  logic          commit,
  input  logic [CW-1:0] commit_len,
  input  logic          ovf_evt,
  output logic [AW-1:0] first,
  output logic [AW-1:0] last,
  output logic [CW-1:0] count,
  output logic          ovf,
  output logic          udf,
  output logic          err
);
  logic [AW-1:0] first_q, first_d, last_q, last_d;
  logic [CW-1:0] count_q, count_d, add_len;
  logic          ovf_q, ovf_d, udf_q, udf_d, rd_ok, udf_evt;

  always_comb begin
    err     = ovf_q || udf_q;
    rd_ok   = rd_en && !err && !flush && (count_q != '0);
    udf_evt = rd_en && !err && !flush && (count_q == '0);
    add_len = commit ? commit_len : '0;
    if (flush) begin
      first_d = '0;
      last_d  = '0;
      count_d = '0;
      ovf_d   = 1'b0;
      udf_d   = 1'b0;
    end else begin
      first_d = first_q + AW'(rd_ok);
      last_d  = last_q + AW'(add_len);
      count_d = count_q - CW'(rd_ok) + add_len;
      ovf_d   = ovf_q || ovf_evt;
      udf_d   = udf_q || udf_evt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      first_q <= '0;
      last_q  <= '0;
      count_q <= '0;
      ovf_q   <= 1'b0;
      udf_q   <= 1'b0;
    end else begin
      first_q <= first_d;
      last_q  <= last_d;
      count_q <= count_d;
      ovf_q   <= ovf_d;
      udf_q   <= udf_d;
    end
  end

  assign first = first_q;
  assign last  = last_q;
  assign count = count_q;
  assign ovf   = ovf_q;
  assign udf   = udf_q;

  // R11: count never exceeds the buffer and matches the pointer distance
  a_r11_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    count_q <= CW'(DEPTH));
  a_r11_count_matches_ptrs: assert property (@(posedge clk) disable iff (!rst_n)
    AW'(last_q - first_q) == AW'(count_q));
  // R8: underflow flag is sticky without a flush
  a_r8_udf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (udf_q && !flush) |=> udf_q);
  // R9: error state freezes all pointers
  a_r9_err_freezes: assert property (@(posedge clk) disable iff (!rst_n)
    (err && !flush) |=> ($stable(first_q) && $stable(last_q) && $stable(count_q)));
  // R1: flush empties the buffer and clears the flags
  a_r1_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (count_q == '0 && !ovf_q && !udf_q));
endmodule

// File: rtl/rx_pkt_fifo.sv
module rx_pkt_fifo
  import rxpf_pkg::*;
#(
  parameter int DEPTH = 128,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_valid,
  input  logic [DW-1:0] wr_data,
  input  logic          wr_sop,
  input  logic          wr_eop,
  input  logic          wr_crc_ok,
  input  logic          rd_en,
  input  logic          flush,
  input  logic          cfg_addr_chk,
  input  logic [DW-1:0] cfg_dev_addr,
  input  logic [DW-1:0] cfg_max_len,
  input  logic          cfg_crc_flush_en,
  input  logic [CW-1:0] cfg_thr,
  output logic [DW-1:0] rd_data,
  output logic [CW-1:0] fill_count,
  output logic [AW-1:0] first_ptr,
  output logic [AW-1:0] last_ptr,
  output logic          thr_hit,
  output logic          ovf_flag,
  output logic          udf_flag,
  output logic [1:0]    discard_code
);
  logic          we_a, we_b, commit, ovf_evt, err;
  logic [AW-1:0] wa_a, wa_b;
  logic [DW-1:0] wd_a, wd_b;
  logic [CW-1:0] commit_len;
  disc_e         code;

  rxpf_admit #(.DEPTH(DEPTH), .DW(DW)) u_admit (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
    .wr_sop(wr_sop), .wr_eop(wr_eop), .wr_crc_ok(wr_crc_ok), .flush(flush),
    .err(err), .count(fill_count), .last(last_ptr),
    .cfg_addr_chk(cfg_addr_chk), .cfg_dev_addr(cfg_dev_addr),
    .cfg_max_len(cfg_max_len), .cfg_crc_flush_en(cfg_crc_flush_en),
    .we_a(we_a), .wa_a(wa_a), .wd_a(wd_a), .we_b(we_b), .wa_b(wa_b), .wd_b(wd_b),
    .commit(commit), .commit_len(commit_len), .ovf_evt(ovf_evt), .code(code)
  );

  rxpf_ptrs #(.DEPTH(DEPTH)) u_ptrs (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .flush(flush), .commit(commit),
    .commit_len(commit_len), .ovf_evt(ovf_evt), .first(first_ptr),
    .last(last_ptr), .count(fill_count), .ovf(ovf_flag), .udf(udf_flag), .err(err)
  );

  rxpf_mem #(.DEPTH(DEPTH), .DW(DW)) u_mem (
    .clk(clk), .we_a(we_a), .wa_a(wa_a), .wd_a(wd_a), .we_b(we_b),
    .wa_b(wa_b), .wd_b(wd_b), .ra(first_ptr), .rd(rd_data)
  );

  assign thr_hit      = fill_count >= cfg_thr;
  assign discard_code = code;

  // R2: the visible end only moves on a final byte or a flush
  a_r2_last_moves_on_eop: assert property (@(posedge clk) disable iff (!rst_n)
    (!(wr_valid && wr_eop) && !flush) |=> $stable(last_ptr));
  // R7: the overflow flag is sticky without a flush
  a_r7_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !flush) |=> ovf_flag);
endmodule

// File: tb/rx_pkt_fifo_bench.sv
module rx_pkt_fifo_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 128;
  localparam int WD_CYCLES = 150000;

  logic clk = 1'b0;
  logic rst_n;
  logic wr_valid, wr_sop, wr_eop, wr_crc_ok, rd_en, flush;
  logic [7:0] wr_data;
  logic cfg_addr_chk, cfg_crc_flush_en;
  logic [7:0] cfg_dev_addr, cfg_max_len, cfg_thr;
  logic [7:0] rd_data, fill_count;
  logic [6:0] first_ptr, last_ptr;
  logic thr_hit, ovf_flag, udf_flag;
  logic [1:0] discard_code;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_pkt_fifo u_rx_pkt_fifo (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
    .wr_sop(wr_sop), .wr_eop(wr_eop), .wr_crc_ok(wr_crc_ok), .rd_en(rd_en),
    .flush(flush), .cfg_addr_chk(cfg_addr_chk), .cfg_dev_addr(cfg_dev_addr),
    .cfg_max_len(cfg_max_len), .cfg_crc_flush_en(cfg_crc_flush_en),
    .cfg_thr(cfg_thr), .rd_data(rd_data), .fill_count(fill_count),
    .first_ptr(first_ptr), .last_ptr(last_ptr), .thr_hit(thr_hit),
    .ovf_flag(ovf_flag), .udf_flag(udf_flag), .discard_code(discard_code)
  );

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  // reference model state
  byte unsigned q[$];
  byte unsigned pq[$];
  bit m_in, m_drop, m_ovf, m_udf, m_arm;
  int m_idx, m_code, m_first, m_last;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    q.delete(); pq.delete();
    m_in = 0; m_drop = 0; m_idx = 0; m_code = 0;
    m_ovf = 0; m_udf = 0; m_first = 0; m_last = 0;
  endtask

  task automatic model_step(bit v, byte unsigned d, bit sop, bit eop, bit crc, bit rd, bit fl);
    int cnt0, ofs, need;
    bit err, arm_old, rlen, raddr, kept;
    cnt0 = q.size();
    err = m_ovf || m_udf;
    arm_old = m_arm;
    m_arm = cfg_crc_flush_en && (fl || m_arm);
    if (fl) begin model_reset(); return; end
    if (rd && !err) begin
      if (cnt0 > 0) begin void'(q.pop_front()); m_first = (m_first + 1) % DEPTH; end
      else m_udf = 1;
    end
    if (v && !err) begin
      ofs = sop ? 0 : pq.size();
      rlen = sop && (d > cfg_max_len);
      raddr = !sop && m_in && !m_drop && m_idx == 1 && cfg_addr_chk && d != cfg_dev_addr;
      kept = sop ? !rlen : (m_in && !m_drop && !raddr);
      need = eop ? 2 : 1;
      if (kept && cnt0 + ofs + need > DEPTH) begin
        m_ovf = 1; m_in = 0; m_drop = 0; pq.delete();
      end else if (sop || m_in) begin
        if (sop) pq.delete();
        if (rlen) m_code = 2; else if (raddr) m_code = 1;
        if (kept) pq.push_back(d);
        if (eop) begin
          if (kept) begin
            if (!crc && arm_old) m_code = 3;
            else begin
              m_code = 0;
              foreach (pq[i]) q.push_back(pq[i]);
              q.push_back(crc ? 8'h80 : 8'h00);
              m_last = (m_last + pq.size() + 1) % DEPTH;
            end
          end
          pq.delete(); m_in = 0; m_drop = 0;
        end else begin
          m_in = 1;
          if (kept) begin m_drop = 0; m_idx = sop ? 1 : (m_idx == 2 ? 2 : m_idx + 1); end
          else begin m_drop = 1; pq.delete(); end
        end
      end
    end
  endtask

  task automatic compare_all();
    check("R2/R11 per-cycle fill_count", fill_count, q.size());
    check("R11 per-cycle first_ptr", first_ptr, m_first);
    check("R2 per-cycle last_ptr", last_ptr, m_last);
    check("R7 per-cycle ovf_flag", ovf_flag, m_ovf);
    check("R8 per-cycle udf_flag", udf_flag, m_udf);
    check("R3/R4/R5 per-cycle discard_code", discard_code, m_code);
    check("R10 per-cycle thr_hit", thr_hit, q.size() >= cfg_thr);
    if (q.size() > 0) check("R2/R11 per-cycle rd_data", rd_data, q[0]);
  endtask

  task automatic cyc(bit v, byte unsigned d, bit sop, bit eop, bit crc, bit rd, bit fl);
    wr_valid = v; wr_data = d; wr_sop = sop; wr_eop = eop; wr_crc_ok = crc;
    rd_en = rd; flush = fl;
    model_step(v, d, sop, eop, crc, rd, fl);
    @(posedge clk);
    @(negedge clk);
    compare_all();
  endtask

  task automatic idle(); cyc(0, 0, 0, 0, 0, 0, 0); endtask
  task automatic do_flush(); cyc(0, 0, 0, 0, 0, 0, 1); endtask
  task automatic rd1(); cyc(0, 0, 0, 0, 0, 1, 0); endtask

  // packet: length byte, address byte, payload; final byte carries crc verdict
  task automatic send(byte unsigned len, byte unsigned addr, int npay, byte unsigned seed, bit crc);
    cyc(1, len, 1, 0, 0, 0, 0);
    cyc(1, addr, 0, (npay == 0), crc, 0, 0);
    for (int i = 0; i < npay; i++)
      cyc(1, byte'(seed + i), 0, (i == npay - 1), crc, 0, 0);
  endtask

  initial begin
    rst_n = 1'b0;
    wr_valid = 0; wr_data = 0; wr_sop = 0; wr_eop = 0; wr_crc_ok = 0;
    rd_en = 0; flush = 0;
    cfg_addr_chk = 1; cfg_dev_addr = 8'h5A; cfg_max_len = 8'd20;
    cfg_crc_flush_en = 1; cfg_thr = 8'd4;
    model_reset(); m_arm = 1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 reset count", fill_count, 0);
    check("R1 reset ptrs", {first_ptr, last_ptr}, 0);
    check("R1 reset flags", {ovf_flag, udf_flag, discard_code}, 0);
    idle();

    // R2 accepted packet, invisible until final byte
    cyc(1, 8'd3, 1, 0, 0, 0, 0);
    cyc(1, 8'h5A, 0, 0, 0, 0, 0);
    cyc(1, 8'h11, 0, 0, 0, 0, 0);
    check("R2 not visible mid-packet", fill_count, 0);
    cyc(1, 8'h22, 0, 1, 1, 0, 0);
    check("R2 committed count", fill_count, 5);
    check("R2 last_ptr", last_ptr, 5);
    check("R2 first byte", rd_data, 8'd3);
    check("R10 thr_hit at 5", thr_hit, 1);
    rd1(); rd1(); rd1();
    check("R11 read order", rd_data, 8'h22);
    check("R10 thr_hit clears at 2", thr_hit, 0);
    rd1();
    check("R2 status byte", rd_data, 8'h80);
    rd1();
    check("R11 empty after reads", fill_count, 0);

    // R3 length filter
    send(8'd30, 8'h5A, 3, 8'h40, 1);
    check("R3 length discard code", discard_code, 2);
    check("R3 nothing visible", fill_count, 0);
    // R4 address filter
    send(8'd5, 8'h33, 3, 8'h50, 1);
    check("R4 address discard code", discard_code, 1);
    check("R4 nothing visible", last_ptr, 5);
    cfg_addr_chk = 0;
    send(8'd5, 8'h33, 2, 8'h60, 1);
    check("R4 address unchecked accepted", fill_count, 5);
    cfg_addr_chk = 1;
    // R5 crc discard
    send(8'd4, 8'h5A, 2, 8'h70, 0);
    check("R5 crc discard code", discard_code, 3);
    check("R5 rolled back", fill_count, 5);
    // R5/R6 disable then re-enable without flush
    cfg_crc_flush_en = 0; idle();
    send(8'd4, 8'h5A, 1, 8'h80, 0);
    check("R5 kept when disarmed", fill_count, 9);
    check("R5 kept code", discard_code, 0);
    cfg_crc_flush_en = 1; idle();
    send(8'd4, 8'h5A, 1, 8'h90, 0);
    check("R6 still disarmed before flush", fill_count, 13);
    do_flush();
    check("R1 flush empties", fill_count, 0);
    send(8'd4, 8'h5A, 1, 8'hA0, 0);
    check("R6 re-armed after flush", discard_code, 3);
    check("R6 bad packet removed", fill_count, 0);

    // R12 stray bytes
    cyc(1, 8'h01, 0, 0, 1, 0, 0);
    cyc(1, 8'h02, 0, 1, 1, 0, 0);
    check("R12 stray bytes ignored", fill_count, 0);

    // R8/R9 underflow and error state
    rd1();
    check("R8 underflow flag", udf_flag, 1);
    send(8'd3, 8'h5A, 1, 8'hB0, 1);
    check("R9 writes ignored in error", fill_count, 0);
    do_flush();
    check("R9 flush clears udf", udf_flag, 0);

    // R11 wrap-around
    for (int k = 0; k < 20; k++) begin
      send(8'd10, 8'h5A, 8, byte'(k * 16), 1);
      for (int j = 0; j < 11; j++) rd1();
    end
    check("R11 last_ptr wraps", last_ptr, (20 * 11) % DEPTH);
    check("R11 first_ptr wraps", first_ptr, (20 * 11) % DEPTH);

    // R7 overflow at exact boundary
    do_flush();
    cfg_max_len = 8'd127; cfg_addr_chk = 0;
    cyc(1, 8'd127, 1, 0, 0, 0, 0);
    for (int i = 0; i < 127; i++) cyc(1, byte'(i), 0, 0, 0, 0, 0);
    check("R7 no overflow at 128 pending", ovf_flag, 0);
    cyc(1, 8'hEE, 0, 0, 0, 0, 0);
    check("R7 overflow on 129th byte", ovf_flag, 1);
    rd1();
    check("R9 read ignored in error", udf_flag, 0);
    check("R9 count frozen", fill_count, 0);
    do_flush();
    check("R1 flush clears ovf", ovf_flag, 0);
    idle();

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired act=hung exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule